// File: doc/BRIEF.md
# Software Interrupt Generation Unit

This block raises software interrupts between processors and keeps their pending state. A processor writes a trigger word. The word names one of the software interrupts, a filter mode and, when the mode uses it, an explicit list of target processors. Every selected target then sees that interrupt pending, and the requesting processor's bit is added to the source mask that the target keeps for that interrupt. Each of the up to 8 processors has its own bank of masks, one for each of the 16 interrupts. A mask bit stands for one requesting processor.

Software can also change source bits directly, through a set window and a clear window. Each window is byte addressed: one byte holds one interrupt's source mask, and an access changes only the state of the processor that issues it. A read port returns four consecutive source masks of any processor, one cycle after the request. The trigger register itself always reads as zero. One pending flag per target and interrupt is driven out as a registered vector. Delivery, prioritisation and acknowledge belong to other blocks.

Top module: `swi_gen_unit`

## Requirements
- R1: While `rst` is high, on the following clock edge every bit of `pend_o` and every source mask becomes zero. `rd_data` also becomes zero.
- R2: A trigger write (`trig_we`) carries three fields. The interrupt number is in bits [3:0], the target list in bits [23:16] and the filter mode in bits [25:24]. With filter mode 0, each processor whose bit is set in the list becomes a target. For each target, the bit of processor `trig_src` is ORed into that target's mask for the named interrupt, and the target's pending flag for that interrupt is set.
- R3: With filter mode 1, the targets are every online processor except `trig_src`.
- R4: With filter mode 2, the only target is `trig_src`.
- R5: Filter mode 3 is reserved. A trigger write in this mode changes no mask and no pending flag.
- R6: A processor with an index equal to or above `online_cnt` is never a target of a trigger write, whatever the list or the mode.
- R7: A set-window write (`win_we` = 1, `win_set` = 1) works on the masks of processor `win_src`. For each byte i of `win_wdata` whose enable bit `win_be[i]` is 1, the byte is ORed into the mask of interrupt `win_addr`+i, and the pending flag follows whether the result is nonzero. A byte whose interrupt number is above 15 is ignored, and so is a byte whose enable bit is 0. A zero byte leaves the pending flag unchanged.
- R8: A clear-window write (`win_we` = 1, `win_set` = 0) removes the written bits from the addressed masks of processor `win_src`, with the same byte-to-interrupt mapping as R7. A pending flag drops only when its mask becomes zero. No pending flag falls except through a clear-window write or through reset.
- R9: A read request (`rd_en`) with `rd_trig` = 0 loads `rd_data` on the next edge. Byte i of `rd_data` holds processor `rd_cpu`'s mask for interrupt `rd_addr`+i, and the byte is zero when that number is above 15. A request with `rd_trig` = 1 loads zero. Without a request, `rd_data` holds its value.
- R10: A trigger write and a window write may arrive in the same cycle. The trigger's ORing is applied first, and the window operation is applied to that result.
- R11: Bit c*16+s of `pend_o` is processor c's pending flag for interrupt s. It is updated on the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| online_cnt | input | 4 | Number of online processors |
| trig_we | input | 1 | Trigger register write strobe |
| trig_src | input | 3 | Processor issuing the trigger write |
| trig_data | input | 32 | Trigger word |
| win_we | input | 1 | Window write strobe |
| win_set | input | 1 | 1 selects the set window, 0 the clear window |
| win_src | input | 3 | Processor issuing the window write; its masks are changed |
| win_addr | input | 4 | Byte offset within the window |
| win_be | input | 4 | Byte enables |
| win_wdata | input | 32 | Window write data, one source mask per byte |
| rd_en | input | 1 | Read request |
| rd_trig | input | 1 | 1 reads the trigger register |
| rd_cpu | input | 3 | Processor whose masks are read |
| rd_addr | input | 4 | Byte offset of the first mask read |
| rd_data | output | 32 | Registered read data |
| pend_o | output | 128 | Registered pending flags, processor-major |

## Verification
The assertions check, on every cycle, that pending flags fall only after a clear-window write or reset. They also check that a reserved-mode trigger leaves the flags untouched, that a self-targeted trigger lands, that the requester never targets itself in mode 1, and that a trigger read returns zero. Only the bench scenarios can show the exact contents of the masks. This covers which targets the list and the online count select, the byte-to-interrupt mapping with its upper cut-off, the OR-then-window ordering of simultaneous writes, and the rule that a pending flag stays high while any source bit remains.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic [1:0] {
    FM_LIST   = 2'd0,
    FM_OTHERS = 2'd1,
    FM_SELF   = 2'd2,
    FM_RSVD   = 2'd3
  } fmode_e;

  // Trigger word field positions
  localparam int TRG_ID_LSB   = 0;
  localparam int TRG_LIST_LSB = 16;
  localparam int TRG_MODE_LSB = 24;
  localparam int BYTE_W       = 8;
endpackage

// File: rtl/swi_target_decode.sv
module swi_target_decode
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W = $clog2(NUM_CPU + 1)
) (
  input  logic [CNT_W-1:0]   online_cnt,
  input  logic [CPU_W-1:0]   src,
  input  logic [NUM_CPU-1:0] list,
  input  fmode_e             mode,
  output logic [NUM_CPU-1:0] tgt
);
  logic [NUM_CPU-1:0] online;
  logic [NUM_CPU-1:0] self_oh;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign online[c]  = (c < int'(online_cnt));
    assign self_oh[c] = (int'(src) == c);
  end

  always_comb begin
    unique case (mode)
      FM_LIST:   tgt = list & online;
      FM_OTHERS: tgt = online & ~self_oh;
      FM_SELF:   tgt = self_oh & online;
      default:   tgt = '0;
    endcase
  end
endmodule

// File: rtl/swi_bank.sv
module swi_bank
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SWI = 16,
  parameter int BYTES   = 4,
  localparam int SWI_W = $clog2(NUM_SWI)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             trig_hit,
  input  logic [SWI_W-1:0]                 trig_id,
  input  logic [NUM_CPU-1:0]               trig_src_oh,
  input  logic                             win_hit,
  input  logic                             win_set,
  input  logic [SWI_W-1:0]                 win_addr,
  input  logic [BYTES-1:0]                 win_be,
  input  logic [BYTES*BYTE_W-1:0]          win_wdata,
  output logic [NUM_SWI-1:0][NUM_CPU-1:0]  mask_q,
  output logic [NUM_SWI-1:0]               pend_q
);
  logic [NUM_SWI-1:0][NUM_CPU-1:0] mask_d;

  always_comb begin
    for (int s = 0; s < NUM_SWI; s++) begin
      mask_d[s] = mask_q[s];
      // trigger ORing first, window op on top of it
      if (trig_hit && (int'(trig_id) == s))
        mask_d[s] = mask_d[s] | trig_src_oh;
      for (int i = 0; i < BYTES; i++) begin
        if (win_hit && win_be[i] && (int'(win_addr) + i == s)) begin
          if (win_set)
            mask_d[s] = mask_d[s] | win_wdata[i*BYTE_W +: NUM_CPU];
          else
            mask_d[s] = mask_d[s] & ~win_wdata[i*BYTE_W +: NUM_CPU];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      for (int s = 0; s < NUM_SWI; s++)
        pend_q[s] <= |mask_d[s];
    end
  end
endmodule

// File: rtl/swi_read_port.sv
module swi_read_port
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SWI = 16,
  parameter int BYTES   = 4,
  localparam int SWI_W = $clog2(NUM_SWI),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          rd_en,
  input  logic                                          rd_trig,
  input  logic [CPU_W-1:0]                              rd_cpu,
  input  logic [SWI_W-1:0]                              rd_addr,
  input  logic [NUM_CPU-1:0][NUM_SWI-1:0][NUM_CPU-1:0]  masks,
  output logic [BYTES*BYTE_W-1:0]                       rd_data
);
  logic [BYTES*BYTE_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (int'(rd_addr) + i < NUM_SWI)
        rd_word[i*BYTE_W +: NUM_CPU] = masks[rd_cpu][int'(rd_addr) + i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_trig ? '0 : rd_word;
  end
endmodule

// File: rtl/swi_gen_unit.sv
module swi_gen_unit
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SWI = 16,
  parameter int DATA_W  = 32,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W = $clog2(NUM_CPU + 1),
  localparam int SWI_W = $clog2(NUM_SWI),
  localparam int BYTES = DATA_W / BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CNT_W-1:0]           online_cnt,
  input  logic                       trig_we,
  input  logic [CPU_W-1:0]           trig_src,
  input  logic [DATA_W-1:0]          trig_data,
  input  logic                       win_we,
  input  logic                       win_set,
  input  logic [CPU_W-1:0]           win_src,
  input  logic [SWI_W-1:0]           win_addr,
  input  logic [BYTES-1:0]           win_be,
  input  logic [DATA_W-1:0]          win_wdata,
  input  logic                       rd_en,
  input  logic                       rd_trig,
  input  logic [CPU_W-1:0]           rd_cpu,
  input  logic [SWI_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_CPU*NUM_SWI-1:0] pend_o
);
  logic [NUM_CPU-1:0]                          tgt;
  logic [NUM_CPU-1:0]                          src_oh;
  logic [SWI_W-1:0]                            trig_id;
  fmode_e                                      trig_mode;
  logic [NUM_CPU-1:0][NUM_SWI-1:0][NUM_CPU-1:0] all_mask;

  assign trig_id   = trig_data[TRG_ID_LSB +: SWI_W];
  assign trig_mode = fmode_e'(trig_data[TRG_MODE_LSB +: 2]);

  swi_target_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .online_cnt (online_cnt),
    .src        (trig_src),
    .list       (trig_data[TRG_LIST_LSB +: NUM_CPU]),
    .mode       (trig_mode),
    .tgt        (tgt)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic [NUM_SWI-1:0] bank_pend;
    assign src_oh[c] = (int'(trig_src) == c);

    swi_bank #(.NUM_CPU(NUM_CPU), .NUM_SWI(NUM_SWI), .BYTES(BYTES)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .trig_hit    (trig_we && tgt[c]),
      .trig_id     (trig_id),
      .trig_src_oh (src_oh),
      .win_hit     (win_we && (int'(win_src) == c)),
      .win_set     (win_set),
      .win_addr    (win_addr),
      .win_be      (win_be),
      .win_wdata   (win_wdata),
      .mask_q      (all_mask[c]),
      .pend_q      (bank_pend)
    );
    assign pend_o[c*NUM_SWI +: NUM_SWI] = bank_pend;
  end

  swi_read_port #(.NUM_CPU(NUM_CPU), .NUM_SWI(NUM_SWI), .BYTES(BYTES)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_trig (rd_trig),
    .rd_cpu  (rd_cpu),
    .rd_addr (rd_addr),
    .masks   (all_mask),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/swi_gen_chk.sv
module swi_gen_chk #(
  parameter int NUM_CPU = 8,
  parameter int NUM_SWI = 16,
  parameter int DATA_W  = 32,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W = $clog2(NUM_CPU + 1)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [CNT_W-1:0]           online_cnt,
  input logic                       trig_we,
  input logic [CPU_W-1:0]           trig_src,
  input logic [DATA_W-1:0]          trig_data,
  input logic                       win_we,
  input logic                       win_set,
  input logic                       rd_en,
  input logic                       rd_trig,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_CPU*NUM_SWI-1:0] pend_o
);
  logic [1:0]  mode;
  int unsigned self_idx;

  assign mode     = trig_data[25:24];
  assign self_idx = int'(trig_src) * NUM_SWI + int'(trig_data[3:0]) % NUM_SWI;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pend_o == '0) && (rd_data == '0));

  a_r8_fall_only_on_clear: assert property (@(posedge clk) disable iff (rst)
    !(win_we && !win_set) |=> (($past(pend_o) & ~pend_o) == '0));

  a_r5_reserved_no_effect: assert property (@(posedge clk) disable iff (rst)
    (trig_we && mode == 2'd3 && !win_we) |=> $stable(pend_o));

  a_r4_self_lands: assert property (@(posedge clk) disable iff (rst)
    (trig_we && mode == 2'd2 && !win_we && int'(trig_src) < int'(online_cnt))
      |=> pend_o[$past(self_idx)]);

  a_r3_requester_excluded: assert property (@(posedge clk) disable iff (rst)
    (trig_we && mode == 2'd1 && !win_we)
      |=> (pend_o[$past(self_idx)] == $past(pend_o[self_idx])));

  a_r9_trig_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_trig) |=> (rd_data == '0));
endmodule

bind swi_gen_unit swi_gen_chk #(.NUM_CPU(NUM_CPU), .NUM_SWI(NUM_SWI), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .online_cnt(online_cnt), .trig_we(trig_we),
  .trig_src(trig_src), .trig_data(trig_data), .win_we(win_we), .win_set(win_set),
  .rd_en(rd_en), .rd_trig(rd_trig), .rd_data(rd_data), .pend_o(pend_o)
);

// File: tb/test_swi_gen_unit.sv
module test_swi_gen_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NS = 16;

  logic        clk = 0;
  logic        rst;
  logic [3:0]  online_cnt;
  logic        trig_we;
  logic [2:0]  trig_src;
  logic [31:0] trig_data;
  logic        win_we, win_set;
  logic [2:0]  win_src;
  logic [3:0]  win_addr;
  logic [3:0]  win_be;
  logic [31:0] win_wdata;
  logic        rd_en, rd_trig;
  logic [2:0]  rd_cpu;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [127:0] pend_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] model [NC][NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  swi_gen_unit i_swi_gen_unit (.*);

  function automatic logic [127:0] exp_pend();
    logic [127:0] p = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) p[c*NS+s] = (model[c][s] != 0);
    return p;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_trig(int src, logic [31:0] d);
    logic [7:0] t;
    case (d[25:24])
      2'd0: t = d[23:16];
      2'd1: t = 8'hFF & ~(8'd1 << src);
      2'd2: t = 8'd1 << src;
      default: t = 8'h00;
    endcase
    for (int c = 0; c < NC; c++)
      if (t[c] && c < int'(online_cnt)) model[c][d[3:0]] |= (8'd1 << src);
  endtask

  task automatic m_win(int src, logic set, int a, logic [3:0] be, logic [31:0] d);
    for (int i = 0; i < 4; i++)
      if (be[i] && a + i < NS) begin
        if (set) model[src][a+i] |= d[i*8 +: 8];
        else     model[src][a+i] &= ~d[i*8 +: 8];
      end
  endtask

  task automatic idle();
    trig_we = 0; win_we = 0; rd_en = 0; rd_trig = 0;
  endtask

  task automatic do_write(logic tw, int ts, logic [31:0] td,
                          logic ww, logic ws, int wsrc, int wa, logic [3:0] wbe, logic [31:0] wd);
    @(negedge clk);
    trig_we = tw; trig_src = 3'(ts); trig_data = td;
    win_we = ww; win_set = ws; win_src = 3'(wsrc); win_addr = 4'(wa); win_be = wbe; win_wdata = wd;
    if (tw) m_trig(ts, td);
    if (ww) m_win(wsrc, ws, wa, wbe, wd);
    @(negedge clk);
    idle();
  endtask

  task automatic check_read(string tag, int cpu, int a, logic trg);
    logic [31:0] e = '0;
    @(negedge clk);
    rd_en = 1; rd_trig = trg; rd_cpu = 3'(cpu); rd_addr = 4'(a);
    @(negedge clk);
    idle();
    if (!trg)
      for (int i = 0; i < 4; i++) if (a + i < NS) e[i*8 +: 8] = model[cpu][a+i];
    check(tag, {96'd0, rd_data}, {96'd0, e});
  endtask

  task automatic t_reset();
    check("R1 pend after reset", pend_o, '0);
    check("R1 rd_data after reset", {96'd0, rd_data}, '0);
  endtask

  task automatic t_mode0();
    // src1, id5, list 0xF5, online 4 -> targets 0 and 2
    do_write(1, 1, 32'h00F5_0005, 0, 0, 0, 0, 0, 0);
    check("R2 R6 R11 mode0 pend", pend_o, exp_pend());
    check_read("R2 R9 mask of cpu0", 0, 4, 0);
    check_read("R6 cpu4 untouched", 4, 4, 0);
  endtask

  task automatic t_mode1();
    do_write(1, 2, 32'h0100_0003, 0, 0, 0, 0, 0, 0);
    check("R3 mode1 pend", pend_o, exp_pend());
    check_read("R3 mask cpu3", 3, 0, 0);
  endtask

  task automatic t_mode2();
    do_write(1, 3, 32'h02FF_0009, 0, 0, 0, 0, 0, 0);
    check("R4 mode2 pend", pend_o, exp_pend());
    check_read("R4 mask cpu3", 3, 8, 0);
  endtask

  task automatic t_mode3();
    do_write(1, 0, 32'h03FF_0001, 0, 0, 0, 0, 0, 0);
    check("R5 reserved pend", pend_o, exp_pend());
    check_read("R5 mask cpu1", 1, 0, 0);
  endtask

  task automatic t_set();
    do_write(0, 0, 0, 1, 1, 1, 14, 4'hF, 32'h1111_8040);
    check("R7 set pend", pend_o, exp_pend());
    check_read("R7 R9 read upper edge", 1, 14, 0);
    do_write(0, 0, 0, 1, 1, 6, 0, 4'b0001, 32'h0000_0000);
    check("R7 zero byte no pend", pend_o, exp_pend());
    do_write(0, 0, 0, 1, 1, 6, 2, 4'b0101, 32'h0077_0022);
    check("R7 byte enables", pend_o, exp_pend());
    check_read("R7 byte enables mask", 6, 2, 0);
  endtask

  task automatic t_clr();
    // cpu0 id5 has bit1; add bit3, then clear bit1: stays pending
    do_write(0, 0, 0, 1, 1, 0, 5, 4'b0001, 32'h0000_0008);
    do_write(0, 0, 0, 1, 0, 0, 5, 4'b0001, 32'h0000_0002);
    check("R8 partial clear keeps pend", pend_o, exp_pend());
    do_write(0, 0, 0, 1, 0, 0, 4, 4'b0010, 32'h0000_0800);
    check("R8 full clear drops pend", pend_o, exp_pend());
    check_read("R8 mask cpu0", 0, 4, 0);
  endtask

  task automatic t_simul();
    // trigger self on cpu0 id7, clear same bit from cpu0 window in same cycle
    do_write(1, 0, 32'h0200_0007, 1, 0, 0, 7, 4'b0001, 32'h0000_0001);
    check("R10 trigger then clear", pend_o, exp_pend());
    do_write(1, 0, 32'h0200_0008, 1, 1, 0, 8, 4'b0001, 32'h0000_0004);
    check("R10 trigger then set", pend_o, exp_pend());
    check_read("R10 mask cpu0", 0, 7, 0);
  endtask

  task automatic t_rd_trig();
    check_read("R9 prime nonzero", 3, 8, 0);
    check_read("R9 trigger reads zero", 3, 8, 1);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) model[c][s] = 0;
    rst = 1; online_cnt = 4; idle();
    trig_src = 0; trig_data = 0; win_set = 0; win_src = 0; win_addr = 0;
    win_be = 0; win_wdata = 0; rd_cpu = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_set();
    t_clr();
    t_simul();
    t_rd_trig();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule